// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by reading a two-level page table held in memory. A translation-cache miss starts it. The cache presents the miss as a request carrying the virtual address and a load/store flag. The walker then makes up to three memory transactions:
- it reads the first-level (directory) entry,
- it reads the second-level (leaf) entry,
- it may write the leaf back.

It ends with a one-cycle completion pulse or a one-cycle fault pulse. The completion pulse carries the physical address and the updated leaf entry, so the cache can be refilled from it.

Each table holds 1024 entries of 4 bytes and fills one 4 KB page. The virtual address is split into fields of 10, 10 and 12 bits, from the top down. Every entry uses the same layout:
- bits [31:12] hold a frame number;
- bit 0 is valid;
- bit 1 is writable;
- bit 2 is used;
- bit 3 is modified.

When a walk succeeds, the walker sets the bookkeeping bits in the leaf entry itself. An invalid directory entry ends the walk at once, because that whole subtree is absent.

The request port is valid/ready, and it takes one walk at a time. `req_ready` is high only while the walker is idle. A request that is offered while the walker is busy is neither stored nor queued. The memory request channel is valid/ready, and the walker holds a request stable until it is accepted. Read data comes back on a separate valid strobe, which the walker cannot stall. Writes return no response. The result pulses are not back-pressured.

Top module: `ptw_walker`

## Requirements
- R1: On completion, `rsp_paddr` equals the leaf entry's frame (bits [31:12]) joined with virtual address bits [11:0].
- R2: The directory read goes to word address {root_frame, vaddr[31:22], 2'b00}. The leaf read goes to {directory entry bits [31:12], vaddr[21:12], 2'b00}. Entry bit 0 is valid, bit 1 writable, bit 2 used, bit 3 modified.
- R3: A directory entry with bit 0 clear gives a fault pulse with `fault_code` 1 after exactly one memory read, and no write.
- R4: A leaf entry with bit 0 clear gives a fault pulse with `fault_code` 2, and no write.
- R5: On a successful walk, the leaf entry in memory gets its used bit (bit 2) set. On a load, the modified bit (bit 3) is not changed.
- R6: On a successful store walk, the leaf entry in memory gets both the used bit and the modified bit set.
- R7: A store to a leaf whose writable bit (bit 1) is clear gives a fault pulse with `fault_code` 3 and leaves the entry unchanged in memory. A load to such a leaf completes normally.
- R8: A request is accepted only in a cycle with `req_ready` high. `busy` is high from the cycle after acceptance up to and including the cycle of the `done` or `fault` pulse. Each pulse lasts one cycle, and the two pulses never occur together.
- R9: The completion pulse presents on `rsp_pte` the leaf entry as it stands after the bookkeeping update.
- R10: If the leaf already has every bookkeeping bit that the access would set, no write-back is issued.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the walker holds the request's address, write flag and write data stable.
- R12: A request offered while the walker is busy is ignored. The walk in progress completes with its own result, and no second walk follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Frame number of the directory table |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Table memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle successful completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 1 = directory absent, 2 = leaf absent, 3 = write to non-writable page |
| rsp_paddr | output | 32 | Translated physical address (valid with `done`) |
| rsp_pte | output | 32 | Updated leaf entry (valid with `done`) |

## Verification
The protection check and the bookkeeping update are both decided in one cycle from the same leaf word. The riskiest case is therefore a store to a read-only page whose used bit is still clear. In that case an update wrongly taken ahead of the protection check would write the entry back. The bench provokes this and expects fault code 3, a write count of zero and the memory word unchanged. It also covers the opposite case, a load to the same kind of page, which must complete and set only the used bit. A second pairing is a new request offered during the very cycle the completion pulse fires. The bench judges it by the result still matching the first address and by no further memory read appearing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // entry bit positions inside a table word
  localparam int unsigned PTE_VALID = 0;
  localparam int unsigned PTE_WRITE = 1;
  localparam int unsigned PTE_USED  = 2;
  localparam int unsigned PTE_MOD   = 3;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_DIR  = 2'd1,
    FLT_LEAF = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT,
    ST_EVAL,
    ST_WBACK,
    ST_FINISH
  } walk_state_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic [VA_W-OFF_W-1:0] root_frame,
  input  logic [VA_W-1:0]       vaddr,
  input  logic [VA_W-OFF_W-1:0] dir_frame,
  input  logic [VA_W-OFF_W-1:0] leaf_frame,
  output logic [VA_W-1:0]       dir_addr,
  output logic [VA_W-1:0]       leaf_addr,
  output logic [VA_W-1:0]       paddr
);
  // entry size shift: one table of 2**IDX_W entries fills one page
  localparam int unsigned ENT_SH = OFF_W - IDX_W;

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] leaf_idx;

  always_comb begin
    dir_idx   = vaddr[VA_W-1 -: IDX_W];
    leaf_idx  = vaddr[VA_W-IDX_W-1 -: IDX_W];
    dir_addr  = {root_frame, dir_idx, {ENT_SH{1'b0}}};
    leaf_addr = {dir_frame, leaf_idx, {ENT_SH{1'b0}}};
    paddr     = {leaf_frame, vaddr[OFF_W-1:0]};
  end

endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W = 32
) (
  input  logic [PTE_W-1:0] leaf_pte,
  input  logic             is_store,
  output logic             absent,
  output logic             prot_fail,
  output logic [PTE_W-1:0] upd_pte,
  output logic             need_wb
);
  always_comb begin
    absent    = !leaf_pte[PTE_VALID];
    prot_fail = is_store && !leaf_pte[PTE_WRITE];
    upd_pte   = leaf_pte;
    upd_pte[PTE_USED] = 1'b1;
    if (is_store) upd_pte[PTE_MOD] = 1'b1;
    need_wb   = (upd_pte != leaf_pte);
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_store,
  input  logic                  mem_req_ready,
  input  logic                  mem_rsp_valid,
  input  logic [PTE_W-1:0]      mem_rsp_rdata,
  input  logic [VA_W-1:0]       dir_addr,
  input  logic [VA_W-1:0]       leaf_addr,
  input  logic                  leaf_absent,
  input  logic                  leaf_prot,
  input  logic                  leaf_need_wb,
  input  logic [PTE_W-1:0]      leaf_upd,
  output logic [VA_W-1:0]       vaddr_q,
  output logic                  store_q,
  output logic [VA_W-OFF_W-1:0] dir_frame_q,
  output logic [PTE_W-1:0]      leaf_q,
  output logic                  mem_req_valid,
  output logic                  mem_req_we,
  output logic [VA_W-1:0]       mem_req_addr,
  output logic [PTE_W-1:0]      mem_req_wdata,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output logic [1:0]            fault_code
);
  localparam int unsigned FRAME_W = VA_W - OFF_W;

  walk_state_e state_q;
  fault_e      code_q;
  logic        fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      code_q      <= FLT_NONE;
      fault_q     <= 1'b0;
      vaddr_q     <= '0;
      store_q     <= 1'b0;
      dir_frame_q <= '0;
      leaf_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          fault_q <= 1'b0;
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            store_q <= req_store;
            state_q <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ:
          if (mem_req_ready) state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT:
          if (mem_rsp_valid) begin
            if (!mem_rsp_rdata[PTE_VALID]) begin
              code_q  <= FLT_DIR;
              fault_q <= 1'b1;
              state_q <= ST_FINISH;
            end else begin
              dir_frame_q <= mem_rsp_rdata[PTE_W-1 -: FRAME_W];
              state_q     <= ST_LEAF_REQ;
            end
          end
        ST_LEAF_REQ:
          if (mem_req_ready) state_q <= ST_LEAF_WAIT;
        ST_LEAF_WAIT:
          if (mem_rsp_valid) begin
            leaf_q  <= mem_rsp_rdata;
            state_q <= ST_EVAL;
          end
        ST_EVAL: begin
          if (leaf_absent) begin
            code_q  <= FLT_LEAF;
            fault_q <= 1'b1;
            state_q <= ST_FINISH;
          end else if (leaf_prot) begin
            code_q  <= FLT_PROT;
            fault_q <= 1'b1;
            state_q <= ST_FINISH;
          end else begin
            leaf_q  <= leaf_upd;
            state_q <= leaf_need_wb ? ST_WBACK : ST_FINISH;
          end
        end
        ST_WBACK:
          if (mem_req_ready) state_q <= ST_FINISH;
        ST_FINISH:
          state_q <= ST_IDLE;
        default:
          state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    busy          = (state_q != ST_IDLE);
    mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_LEAF_REQ) ||
                    (state_q == ST_WBACK);
    mem_req_we    = (state_q == ST_WBACK);
    mem_req_addr  = (state_q == ST_DIR_REQ) ? dir_addr : leaf_addr;
    mem_req_wdata = leaf_q;
    done          = (state_q == ST_FINISH) && !fault_q;
    fault         = (state_q == ST_FINISH) && fault_q;
    fault_code    = code_q;
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PTE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [VA_W-OFF_W-1:0] root_frame,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_store,
  output logic                  busy,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_we,
  output logic [VA_W-1:0]       mem_req_addr,
  output logic [PTE_W-1:0]      mem_req_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [PTE_W-1:0]      mem_rsp_rdata,
  output logic                  done,
  output logic                  fault,
  output logic [1:0]            fault_code,
  output logic [VA_W-1:0]       rsp_paddr,
  output logic [PTE_W-1:0]      rsp_pte
);
  localparam int unsigned FRAME_W = VA_W - OFF_W;

  logic [VA_W-1:0]    vaddr_q;
  logic               store_q;
  logic [FRAME_W-1:0] dir_frame_q;
  logic [PTE_W-1:0]   leaf_q;
  logic [VA_W-1:0]    dir_addr;
  logic [VA_W-1:0]    leaf_addr;
  logic               leaf_absent;
  logic               leaf_prot;
  logic               leaf_need_wb;
  logic [PTE_W-1:0]   leaf_upd;

  ptw_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .root_frame (root_frame),
    .vaddr      (vaddr_q),
    .dir_frame  (dir_frame_q),
    .leaf_frame (leaf_q[PTE_W-1 -: FRAME_W]),
    .dir_addr   (dir_addr),
    .leaf_addr  (leaf_addr),
    .paddr      (rsp_paddr)
  );

  ptw_leaf_eval #(.PTE_W(PTE_W)) u_eval (
    .leaf_pte  (leaf_q),
    .is_store  (store_q),
    .absent    (leaf_absent),
    .prot_fail (leaf_prot),
    .upd_pte   (leaf_upd),
    .need_wb   (leaf_need_wb)
  );

  ptw_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .PTE_W(PTE_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_store     (req_store),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .dir_addr      (dir_addr),
    .leaf_addr     (leaf_addr),
    .leaf_absent   (leaf_absent),
    .leaf_prot     (leaf_prot),
    .leaf_need_wb  (leaf_need_wb),
    .leaf_upd      (leaf_upd),
    .vaddr_q       (vaddr_q),
    .store_q       (store_q),
    .dir_frame_q   (dir_frame_q),
    .leaf_q        (leaf_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .busy          (busy),
    .done          (done),
    .fault         (fault),
    .fault_code    (fault_code)
  );

  assign rsp_pte = leaf_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             req_store,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we,
  input logic [VA_W-1:0]  mem_req_addr,
  input logic [PTE_W-1:0] mem_req_wdata,
  input logic             done,
  input logic             fault,
  input logic [1:0]       fault_code,
  input logic [VA_W-1:0]  rsp_paddr,
  input logic [PTE_W-1:0] rsp_pte
);
  logic [OFF_W-1:0] off_cap;
  logic             store_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_cap   <= '0;
      store_cap <= 1'b0;
    end else if (req_valid && req_ready) begin
      off_cap   <= req_vaddr[OFF_W-1:0];
      store_cap <= req_store;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R8
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !busy && !done && !fault); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R11
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rsp_paddr[OFF_W-1:0] == off_cap); // R1
  AST_USED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rsp_pte[2]); // R5
  AST_STORE_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    done && store_cap |-> rsp_pte[3]); // R6
  AST_PROT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    fault && fault_code == 2'd3 |-> store_cap); // R7
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_code != 2'd0); // R3

endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PTE_W(PTE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .req_store     (req_store),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .done          (done),
  .fault         (fault),
  .fault_code    (fault_code),
  .rsp_paddr     (rsp_paddr),
  .rsp_pte       (rsp_pte)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam logic [19:0] ROOT = 20'h00010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] root_frame = ROOT;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        done;
  logic        fault;
  logic [1:0]  fault_code;
  logic [31:0] rsp_paddr;
  logic [31:0] rsp_pte;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] rd_last = '0;
  logic [31:0] rd_prev = '0;
  logic        stall_en = 1'b0;
  logic [31:0] mem [logic [31:0]];

  // results of the last walk
  logic        g_done, g_fault, g_busy_ok;
  logic [1:0]  g_code;
  logic [31:0] g_paddr, g_pte;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_store(req_store), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .done(done), .fault(fault),
    .fault_code(fault_code), .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte)
  );

  assign mem_req_ready = !stall_en || (cyc % 3 == 2);

  // table memory model: read data returns one cycle after acceptance
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
        rd_cnt  <= rd_cnt + 1;
        rd_prev <= rd_last;
        rd_last <= mem_req_addr;
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    bad = bad + 1;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    summary();
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_a(input logic [31:0] va);
    return {ROOT, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] leaf_a(input logic [19:0] tbl, input logic [31:0] va);
    return {tbl, va[21:12], 2'b00};
  endfunction

  task automatic map(input logic [31:0] va, input logic [19:0] tbl, input logic [31:0] pte);
    mem[dir_a(va)] = {tbl, 12'h001};
    mem[leaf_a(tbl, va)] = pte;
  endtask

  // run one walk; with noise set, a second request is offered during the walk
  task automatic walk(input logic [31:0] va, input logic st, input logic noise);
    int n;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_store = st;
    @(negedge clk);
    req_valid = noise;
    req_vaddr = va ^ 32'hFFFF_F000;
    req_store = ~st;
    g_busy_ok = 1'b1;
    n = 0;
    while (!(done || fault) && n < 200) begin
      if (!busy || req_ready) g_busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    if (!busy) g_busy_ok = 1'b0;
    g_done = done; g_fault = fault; g_code = fault_code;
    g_paddr = rsp_paddr; g_pte = rsp_pte;
    req_valid = 1'b0;
    @(negedge clk);
    if (busy || done || fault) g_busy_ok = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy && req_ready, "R8 reset idle", {30'd0, busy, req_ready}, 32'h1);
    chk(!done && !fault && !mem_req_valid, "R8 reset quiet",
        {29'd0, done, fault, mem_req_valid}, 32'h0);
  endtask

  task automatic t_load_ok();
    logic [31:0] va = 32'h1234_5ABC;
    int r0 = rd_cnt, w0 = wr_cnt;
    map(va, 20'h00200, 32'hABCDE_003);
    walk(va, 1'b0, 1'b0);
    chk(g_done && !g_fault, "R1 load completes", {30'd0, g_done, g_fault}, 32'h2);
    chk(g_paddr == 32'hABCDE_ABC, "R1 paddr", g_paddr, 32'hABCDE_ABC);
    chk(rd_prev == dir_a(va), "R2 directory address", rd_prev, dir_a(va));
    chk(rd_last == leaf_a(20'h00200, va), "R2 leaf address", rd_last, leaf_a(20'h00200, va));
    chk(rd_cnt - r0 == 2, "R2 two reads", rd_cnt - r0, 2);
    chk(mem[leaf_a(20'h00200, va)] == 32'hABCDE_007, "R5 used bit stored",
        mem[leaf_a(20'h00200, va)], 32'hABCDE_007);
    chk(wr_cnt - w0 == 1, "R5 one write-back", wr_cnt - w0, 1);
    chk(g_pte == 32'hABCDE_007, "R9 returned entry", g_pte, 32'hABCDE_007);
    chk(g_busy_ok, "R8 busy window", {31'd0, g_busy_ok}, 1);
  endtask

  task automatic t_store_ok();
    logic [31:0] va = 32'h8000_1004;
    map(va, 20'h00300, 32'h55555_003);
    walk(va, 1'b1, 1'b0);
    chk(g_done && g_paddr == 32'h55555_004, "R6 store paddr", g_paddr, 32'h55555_004);
    chk(mem[leaf_a(20'h00300, va)] == 32'h55555_00F, "R6 used and modified",
        mem[leaf_a(20'h00300, va)], 32'h55555_00F);
    chk(g_pte == 32'h55555_00F, "R9 store entry", g_pte, 32'h55555_00F);
  endtask

  task automatic t_prot();
    logic [31:0] va = 32'h4040_3FF8;
    int w0;
    map(va, 20'h00400, 32'h77777_001);
    w0 = wr_cnt;
    walk(va, 1'b1, 1'b0);
    chk(g_fault && !g_done && g_code == 2'd3, "R7 protection fault",
        {28'd0, g_fault, g_done, g_code}, 32'h b);
    chk(wr_cnt == w0 && mem[leaf_a(20'h00400, va)] == 32'h77777_001,
        "R7 entry untouched", mem[leaf_a(20'h00400, va)], 32'h77777_001);
    walk(va, 1'b0, 1'b0);
    chk(g_done && mem[leaf_a(20'h00400, va)] == 32'h77777_005, "R7 load on read-only",
        mem[leaf_a(20'h00400, va)], 32'h77777_005);
  endtask

  task automatic t_dir_absent();
    logic [31:0] va = 32'hC000_0123;
    int r0, w0;
    mem[dir_a(va)] = 32'h00500_000;
    r0 = rd_cnt; w0 = wr_cnt;
    walk(va, 1'b0, 1'b0);
    chk(g_fault && g_code == 2'd1, "R3 directory fault", {29'd0, g_fault, g_code}, 32'h5);
    chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R3 one read no write", rd_cnt - r0, 1);
  endtask

  task automatic t_leaf_absent();
    logic [31:0] va = 32'h0040_2000;
    int w0;
    map(va, 20'h00600, 32'h12345_00E);
    w0 = wr_cnt;
    walk(va, 1'b1, 1'b0);
    chk(g_fault && g_code == 2'd2, "R4 leaf fault", {29'd0, g_fault, g_code}, 32'h6);
    chk(wr_cnt == w0, "R4 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_no_wb();
    logic [31:0] va = 32'h0080_0010;
    int w0;
    map(va, 20'h00700, 32'h0ABCD_007);
    w0 = wr_cnt;
    walk(va, 1'b0, 1'b0);
    chk(g_done && wr_cnt == w0, "R10 load no write", wr_cnt - w0, 0);
    mem[leaf_a(20'h00700, va)] = 32'h0ABCD_00F;
    walk(va, 1'b1, 1'b0);
    chk(g_done && wr_cnt == w0 && g_pte == 32'h0ABCD_00F, "R10 store no write",
        wr_cnt - w0, 0);
  endtask

  task automatic t_stall();
    logic [31:0] va = 32'hFFC0_0FFF;
    int w0;
    stall_en = 1'b1;
    map(va, 20'h00800, 32'hFEDCB_003);
    w0 = wr_cnt;
    walk(va, 1'b1, 1'b0);
    chk(g_done && g_paddr == 32'hFEDCB_FFF, "R11 stalled walk paddr", g_paddr, 32'hFEDCB_FFF);
    chk(wr_cnt - w0 == 1 && mem[leaf_a(20'h00800, va)] == 32'hFEDCB_00F,
        "R11 stalled write-back", mem[leaf_a(20'h00800, va)], 32'hFEDCB_00F);
    stall_en = 1'b0;
  endtask

  task automatic t_busy_ignore();
    logic [31:0] va = 32'h0C00_5678;
    int r0;
    map(va, 20'h00900, 32'h31415_003);
    map(va ^ 32'hFFFF_F000, 20'h00A00, 32'h27182_003);
    r0 = rd_cnt;
    walk(va, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(g_done && g_paddr == 32'h31415_678, "R12 first walk result", g_paddr, 32'h31415_678);
    chk(rd_cnt - r0 == 2 && !busy, "R12 no second walk", rd_cnt - r0, 2);
    chk(g_busy_ok, "R8 busy during ignored request", {31'd0, g_busy_ok}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load_ok();
    t_store_ok();
    t_prot();
    t_dir_absent();
    t_leaf_absent();
    t_no_wb();
    t_stall();
    t_busy_ignore();
    summary();
  end

endmodule